// File: doc/BRIEF.md
# Fixed-Weight Score Blender with Serial and Parallel Datapaths

The block forms the weighted total of four unsigned 8-bit scores, with weights of one, two, three and four tenths held as fixed-point constants with eight fractional bits. Two datapaths compute the same total side by side. The serial path has one multiplier and one adder. It latches the scores on a start pulse and folds in one weighted term per clock. The parallel path has one multiplier per term and a reduction tree of adders, and it delivers a registered total every clock.

A host either drives the scores and reads the parallel total one cycle later, or pulses start and waits for the serial path's done flag. Both totals are exact, with no rounding, so the two paths give the same value bit for bit for the same scores. Placing both paths side by side lets their latency and area be compared on the same expression.

Top module: `wsum_top`

## Requirements
- R1: The total is 26*a + 51*b + 77*c + 102*d, with eight fractional bits and no truncation. Score a sits in bits 7:0 of `scores_i`, b in bits 15:8, c in bits 23:16 and d in bits 31:24.
- R2: `par_sum_o` equals the R1 total of the `scores_i` value sampled at the previous rising clock edge. It updates on every clock.
- R3: A start sampled while the serial path is idle latches `scores_i` and clears `seq_sum_o` to zero at that edge. Later changes to `scores_i` do not affect the run.
- R4: On each of the next four edges the serial path adds one weighted term, in the order a, b, c, d. After k edges, `seq_sum_o` shows the sum of the first k terms.
- R5: `seq_done_o` is high for exactly one cycle. It rises at the fourth edge after the edge that accepted start.
- R6: A start sampled during any of the four accumulation edges, including the last one, is ignored. It neither clears nor restarts the run.
- R7: A start sampled in the cycle where `seq_done_o` is high is accepted and begins a new run.
- R8: After done, `seq_sum_o` holds the final total until the next accepted start. That total equals `par_sum_o` for the same scores.
- R9: While `rst_ni` is low, both totals, the step counter and `seq_done_o` are cleared to zero.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches a serial run when the serial path is idle |
| scores_i | input | 32 | Four packed 8-bit scores, a in the low byte |
| par_sum_o | output | 18 | Parallel path total, registered |
| seq_sum_o | output | 18 | Serial path accumulator |
| seq_done_o | output | 1 | One-cycle pulse when the serial total is complete |

## Verification
The interesting coincidences are a start pulse that lands on the fourth accumulation edge, and a start pulse that lands in the cycle where done is high. The bench drives start exactly on each of those edges. In the first case it expects done to pulse and the old total to persist. In the second case it expects the accumulator to read zero on the following cycle. Throughout, the parallel total is compared with a bench-computed model on every cycle, while the serial path is busy on other scores.

// File: rtl/wsum_pkg.sv
`timescale 1ns/1ps
package wsum_pkg;
  // weight of term idx = round((idx+1)/10 * 256)
  function automatic int unsigned wgt_of(int unsigned idx);
    return ((idx + 1) * 512 + 10) / 20;
  endfunction
endpackage

// File: rtl/wsum_mul.sv
`timescale 1ns/1ps
module wsum_mul #(
  parameter int A_W = 8,
  parameter int B_W = 8,
  localparam int P_W = A_W + B_W
) (
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic [P_W-1:0] p_o
);
  assign p_o = P_W'(a_i) * P_W'(b_i);
endmodule

// File: rtl/wsum_par.sv
`timescale 1ns/1ps
module wsum_par #(
  parameter int N_TERMS = 4,
  parameter int SCORE_W = 8,
  parameter int WGT_W   = 8,
  parameter int SUM_W   = 18
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_TERMS*SCORE_W-1:0] scores_i,
  output logic [SUM_W-1:0]           sum_o
);
  import wsum_pkg::*;
  localparam int P_W   = SCORE_W + WGT_W;
  localparam int NODES = 2 * N_TERMS - 1;

  logic [SUM_W-1:0] node [NODES];

  for (genvar i = 0; i < N_TERMS; i++) begin : g_leaf
    logic [P_W-1:0] prod;
    wsum_mul #(.A_W(SCORE_W), .B_W(WGT_W)) u_mul (
      .a_i (scores_i[i*SCORE_W +: SCORE_W]),
      .b_i (WGT_W'(wgt_of(i))),
      .p_o (prod)
    );
    assign node[N_TERMS-1+i] = SUM_W'(prod);
  end

  // heap-ordered reduction tree: N_TERMS-1 adders
  for (genvar k = 0; k < N_TERMS - 1; k++) begin : g_add
    assign node[k] = node[2*k+1] + node[2*k+2];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_o <= '0;
    else         sum_o <= node[0];
  end
endmodule

// File: rtl/wsum_seq.sv
`timescale 1ns/1ps
module wsum_seq #(
  parameter int N_TERMS = 4,
  parameter int SCORE_W = 8,
  parameter int WGT_W   = 8,
  parameter int SUM_W   = 18
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [N_TERMS*SCORE_W-1:0] scores_i,
  output logic [SUM_W-1:0]           sum_o,
  output logic                       busy_o,
  output logic                       done_o
);
  import wsum_pkg::*;
  localparam int P_W    = SCORE_W + WGT_W;
  localparam int STEP_W = (N_TERMS > 1) ? $clog2(N_TERMS) : 1;
  localparam logic [STEP_W-1:0] LAST = STEP_W'(N_TERMS - 1);

  logic [SCORE_W-1:0] hold_q [N_TERMS];
  logic [WGT_W-1:0]   wtab   [N_TERMS];
  logic [STEP_W-1:0]  step_q;
  logic [SUM_W-1:0]   acc_q;
  logic               busy_q, done_q;
  logic [P_W-1:0]     prod;

  for (genvar i = 0; i < N_TERMS; i++) begin : g_wtab
    assign wtab[i] = WGT_W'(wgt_of(i));
  end

  wsum_mul #(.A_W(SCORE_W), .B_W(WGT_W)) u_mul (
    .a_i (hold_q[step_q]),
    .b_i (wtab[step_q]),
    .p_o (prod)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
      acc_q  <= '0;
      for (int i = 0; i < N_TERMS; i++) hold_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          step_q <= '0;
          acc_q  <= '0;
          for (int i = 0; i < N_TERMS; i++) hold_q[i] <= scores_i[i*SCORE_W +: SCORE_W];
        end
      end else begin
        acc_q  <= acc_q + SUM_W'(prod);
        step_q <= step_q + 1'b1;
        if (step_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          step_q <= '0;
        end
      end
    end
  end

  assign sum_o  = acc_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/wsum_top.sv
`timescale 1ns/1ps
module wsum_top #(
  parameter int N_TERMS = 4,
  parameter int SCORE_W = 8,
  parameter int WGT_W   = 8,
  localparam int SUM_W  = SCORE_W + WGT_W + $clog2(N_TERMS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [N_TERMS*SCORE_W-1:0] scores_i,
  output logic [SUM_W-1:0]           par_sum_o,
  output logic [SUM_W-1:0]           seq_sum_o,
  output logic                       seq_done_o
);
  logic seq_busy;

  wsum_par #(.N_TERMS(N_TERMS), .SCORE_W(SCORE_W), .WGT_W(WGT_W), .SUM_W(SUM_W)) u_par (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .scores_i (scores_i),
    .sum_o    (par_sum_o)
  );

  wsum_seq #(.N_TERMS(N_TERMS), .SCORE_W(SCORE_W), .WGT_W(WGT_W), .SUM_W(SUM_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .scores_i (scores_i),
    .sum_o    (seq_sum_o),
    .busy_o   (seq_busy),
    .done_o   (seq_done_o)
  );
endmodule

// File: rtl/wsum_chk.sv
`timescale 1ns/1ps
module wsum_chk #(
  parameter int N_TERMS = 4,
  parameter int SCORE_W = 8,
  parameter int SUM_W   = 18
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       start_i,
  input logic [N_TERMS*SCORE_W-1:0] scores_i,
  input logic                       busy_i,
  input logic                       done_i,
  input logic [SUM_W-1:0]           seq_sum_i,
  input logic [SUM_W-1:0]           par_sum_i
);
  localparam int CNT_W = $clog2(N_TERMS + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(N_TERMS);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  // independent run tracker: 0 idle, 1..N accumulation steps pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (cnt_q == '0)          cnt_q <= start_i ? CNT_W'(1) : '0;
      else if (cnt_q == CNT_END) cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_BUSY_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i == (cnt_q != '0));                                            // R6
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cnt_q == '0) |=> (seq_sum_i == '0));                     // R3
  AST_DONE_ON_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_END) |=> done_i);                                      // R5
  AST_DONE_ONLY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != CNT_END) |=> !done_i);                                     // R5
  AST_ACC_MONOTONIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> (seq_sum_i >= $past(seq_sum_i)));                  // R4
  AST_SEQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !start_i) |=> $stable(seq_sum_i));                   // R8
  AST_PAR_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $stable(scores_i)) |=> $stable(par_sum_i));              // R2
endmodule

bind wsum_top wsum_chk #(.N_TERMS(N_TERMS), .SCORE_W(SCORE_W), .SUM_W(SUM_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .scores_i  (scores_i),
  .busy_i    (seq_busy),
  .done_i    (seq_done_o),
  .seq_sum_i (seq_sum_o),
  .par_sum_i (par_sum_o)
);

// File: tb/wsum_top_bench.sv
`timescale 1ns/1ps
module wsum_top_bench;
  localparam int SUM_W = 18;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [31:0]      scores = '0;
  logic [SUM_W-1:0] par_sum, seq_sum;
  logic             seq_done;

  int checks = 0;
  int fails  = 0;
  bit par_en = 1'b0;
  bit finished = 1'b0;

  wsum_top u_wsum_top (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .scores_i   (scores),
    .par_sum_o  (par_sum),
    .seq_sum_o  (seq_sum),
    .seq_done_o (seq_done)
  );

  always #10 clk = ~clk;

  function automatic int unsigned wgt(int i);
    case (i)
      0: return 26;
      1: return 51;
      2: return 77;
      default: return 102;
    endcase
  endfunction

  function automatic int unsigned partial(logic [31:0] s, int k);
    int unsigned acc = 0;
    for (int i = 0; i < k; i++) acc += wgt(i) * s[i*8 +: 8];
    return acc;
  endfunction

  task automatic chk(string req, int unsigned act, int unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // one clock; outputs sampled at the falling edge
  task automatic tick();
    logic [31:0] prev = scores;
    @(posedge clk);
    @(negedge clk);
    if (par_en) chk("R2 parallel total", par_sum, partial(prev, 4));
  endtask

  // ends at the falling edge after the done pulse rises
  task automatic seq_run(logic [31:0] s, bit late, string first_tag);
    scores = s;
    start  = 1'b1;
    tick();
    start  = 1'b0;
    chk(first_tag, seq_sum, 0);
    chk("R5 no done at accept", seq_done, 0);
    scores = $urandom;                           // R3: must not disturb the run
    for (int k = 1; k <= 4; k++) begin
      if (k == 4 && late) begin                  // R6: start on the final step
        start  = 1'b1;
        scores = $urandom;
      end
      tick();
      start = 1'b0;
      chk("R4 partial sum", seq_sum, partial(s, k));
      chk("R5 done timing", seq_done, (k == 4) ? 1 : 0);
    end
  endtask

  task automatic hold_check(logic [31:0] s, int idle);
    for (int i = 0; i < idle; i++) begin
      scores = $urandom;
      tick();
      chk("R5 done single pulse", seq_done, 0);
      chk("R8 total held", seq_sum, partial(s, 4));
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    @(negedge clk);
    chk("R9 reset par", par_sum, 0);
    chk("R9 reset seq", seq_sum, 0);
    chk("R9 reset done", seq_done, 0);
    rst_n = 1'b1;
    tick();
    par_en = 1'b1;

    // R1: extremes and single-term patterns
    scores = 32'hFFFF_FFFF; tick(); chk("R1 all max", par_sum, 65280);
    scores = 32'h0000_0001; tick(); chk("R1 weight a", par_sum, 26);
    scores = 32'h0000_0100; tick(); chk("R1 weight b", par_sum, 51);
    scores = 32'h0001_0000; tick(); chk("R1 weight c", par_sum, 77);
    scores = 32'h0100_0000; tick(); chk("R1 weight d", par_sum, 102);
    scores = 32'h0;         tick(); chk("R1 all zero", par_sum, 0);

    // R8: serial equals parallel for all-max
    seq_run(32'hFFFF_FFFF, 1'b0, "R3 clear on start");
    hold_check(32'hFFFF_FFFF, 2);
    scores = 32'hFFFF_FFFF; tick();
    chk("R8 paths agree", seq_sum, par_sum);

    // R6: start on the final accumulation edge is ignored
    seq_run(32'h4080_C010, 1'b1, "R3 clear on start");
    hold_check(32'h4080_C010, 3);

    // R6: start mid-run is ignored
    begin
      logic [31:0] s = 32'h0A14_1E28;
      scores = s; start = 1'b1; tick(); start = 1'b0;
      tick();
      start = 1'b1; scores = 32'hFFFF_FFFF; tick(); start = 1'b0;
      chk("R6 mid-run start ignored", seq_sum, partial(s, 2));
      tick(); tick();
      chk("R6 run completes", seq_done, 1);
      chk("R6 run total", seq_sum, partial(s, 4));
      hold_check(s, 1);
    end

    // R7: back-to-back runs, start in the done cycle
    begin
      logic [31:0] s0 = $urandom;
      logic [31:0] s1 = $urandom;
      seq_run(s0, 1'b0, "R3 clear on start");
      seq_run(s1, 1'b0, "R7 start in done cycle");
      hold_check(s1, 1);
    end

    // random runs
    for (int n = 0; n < 60; n++) begin
      logic [31:0] s = $urandom;
      bit late = ($urandom % 3) == 0;
      seq_run(s, late, "R3 clear on start");
      if (!late && ($urandom % 2)) continue;   // chain next run into done cycle
      hold_check(s, 1 + ($urandom % 3));
    end
    hold_check(seq_sum == 0 ? 0 : 0, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule